// File: doc/BRIEF.md
# Debug Address Match Unit

This block watches a soft processor's instruction fetch and data access streams and compares them against a small set of debugger-programmed addresses. Instruction-address slots raise a breakpoint request when the fetched program counter equals an armed slot's address. Data-address slots carry an access-kind mode and raise a watchpoint request when a load or store of the selected kind touches exactly the programmed byte address.

A data match has to stop the access before it takes effect. For this reason the unit drives a combinational block signal in the same cycle as the access. The memory stage uses it to suppress the store or load. The two request outputs are registered once and go to the exception logic. Slots are set and cleared through a synchronous write port. A write changes comparisons from the following cycle on.

Top module: `dbg_match_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bp_req`, `wp_req` and `mem_block` are 0. Every slot is empty after reset, so no access matches until a slot is programmed.
- R2: When `pc_valid` is 1 and `pc` equals the address of a set instruction slot, `bp_req` is 1 in the next cycle. When `pc_valid` is 0, no breakpoint is raised whatever `pc` holds.
- R3: A data slot in mode 0 (off) never matches, whatever address it holds and whatever the access kind.
- R4: A data slot in mode 1 matches loads only (`mem_we` = 0).
- R5: A data slot in mode 2 matches stores only (`mem_we` = 1).
- R6: A data slot in mode 3 matches both loads and stores.
- R7: A data match needs `mem_addr` to equal the slot's byte address exactly. Neighbouring byte addresses do not match.
- R8: A data match drives `mem_block` to 1 combinationally in the same cycle as the access (`mem_req` = 1), and drives `wp_req` to 1 in the next cycle. `mem_block` is never 1 without `mem_req`.
- R9: A cleared slot (`cfg_clr` = 1) no longer matches. Clearing a slot that is already empty changes nothing, and other slots keep matching.
- R10: A configuration write (`cfg_wr` = 1; `cfg_kind` 0 selects an instruction slot, 1 a data slot; `cfg_slot` is the index) affects only accesses from the following cycle on. An access in the same cycle as the write uses the previous setting.
- R11: The requests are the OR over all slots of their kind. Any matching slot raises its request, and breakpoint and watchpoint requests can rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0 = instruction slot, 1 = data slot |
| cfg_clr | input | 1 | 1 = clear the slot, 0 = set it |
| cfg_slot | input | 2 | Slot index |
| cfg_addr | input | 32 | Address to store in the slot |
| cfg_mode | input | 2 | Data slot mode: 0 off, 1 load, 2 store, 3 both |
| pc_valid | input | 1 | A fetch is presented this cycle |
| pc | input | 32 | Fetch address |
| mem_req | input | 1 | A data access is presented this cycle |
| mem_we | input | 1 | 1 = store, 0 = load |
| mem_addr | input | 32 | Data byte address |
| mem_block | output | 1 | Suppress the current data access (combinational) |
| bp_req | output | 1 | Breakpoint request, registered |
| wp_req | output | 1 | Watchpoint request, registered |

## Verification
The hardest situation to reach is a configuration write that lands in the same cycle as an access to the address being programmed. It also has to be told apart from a match on an old setting still held in the slot. The stimulus first clears the target slot. It then issues the write and a store to the new address in one cycle, which must pass unblocked, and repeats the store in the next cycle, which must be blocked. A cycle-level reference model checks `mem_block` on every cycle and both registered requests, including during runs of mixed fetches, loads and stores over a small shared address set, so that several slots match together.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

   typedef enum logic [1:0] {
      WM_OFF   = 2'd0,
      WM_LOAD  = 2'd1,
      WM_STORE = 2'd2,
      WM_ANY   = 2'd3
   } wmode_e;

   // Does a slot in mode m accept an access of the given kind?
   function automatic logic mode_accepts(input logic [1:0] m, input logic is_store);
      case (wmode_e'(m))
         WM_LOAD:  return !is_store;
         WM_STORE: return is_store;
         WM_ANY:   return 1'b1;
         default:  return 1'b0;
      endcase
   endfunction

   function automatic int idx_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dbg_slot_bank.sv
module dbg_slot_bank
   import dbg_match_pkg::*;
#(
   parameter int NUM      = 4,
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 2,
   parameter bit HAS_MODE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic                       wr_clr,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [1:0]                 wr_mode,
   output logic [NUM-1:0]             slot_valid,
   output logic [NUM-1:0][ADDR_W-1:0] slot_addr,
   output logic [NUM-1:0][1:0]        slot_mode
);

   initial begin
      if (NUM < 1)              $error("dbg_slot_bank: NUM must be at least 1");
      if ((1 << IDX_W) < NUM)   $error("dbg_slot_bank: IDX_W too narrow for NUM");
   end

   for (genvar g = 0; g < NUM; g++) begin : g_slot
      logic hit_sel;
      assign hit_sel = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_valid[g] <= 1'b0;
            slot_addr[g]  <= '0;
         end else if (hit_sel) begin
            slot_valid[g] <= !wr_clr;
            slot_addr[g]  <= wr_clr ? '0 : wr_addr;
         end
      end

      if (HAS_MODE) begin : g_mode
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       slot_mode[g] <= WM_OFF;
            else if (hit_sel) slot_mode[g] <= wr_clr ? WM_OFF : wr_mode;
         end
      end else begin : g_nomode
         assign slot_mode[g] = WM_ANY;
      end
   end

   if (!HAS_MODE) begin : g_sink
      logic [1:0] unused_mode_bits;
      assign unused_mode_bits = wr_mode;
   end

endmodule

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp #(
   parameter int NUM    = 4,
   parameter int ADDR_W = 32
) (
   input  logic [NUM-1:0]             slot_valid,
   input  logic [NUM-1:0][ADDR_W-1:0] slot_addr,
   input  logic                       pc_valid,
   input  logic [ADDR_W-1:0]          pc,
   output logic [NUM-1:0]             hit_vec
);

   for (genvar g = 0; g < NUM; g++) begin : g_cmp
      assign hit_vec[g] = pc_valid && slot_valid[g] && (slot_addr[g] == pc);
   end

endmodule

// File: rtl/dbg_wp_cmp.sv
module dbg_wp_cmp
   import dbg_match_pkg::*;
#(
   parameter int NUM    = 4,
   parameter int ADDR_W = 32
) (
   input  logic [NUM-1:0]             slot_valid,
   input  logic [NUM-1:0][ADDR_W-1:0] slot_addr,
   input  logic [NUM-1:0][1:0]        slot_mode,
   input  logic                       mem_req,
   input  logic                       mem_we,
   input  logic [ADDR_W-1:0]          mem_addr,
   output logic [NUM-1:0]             hit_vec
);

   for (genvar g = 0; g < NUM; g++) begin : g_cmp
      logic kind_ok;
      logic addr_ok;
      assign kind_ok    = mode_accepts(slot_mode[g], mem_we);
      assign addr_ok    = (slot_addr[g] == mem_addr);
      assign hit_vec[g] = mem_req && slot_valid[g] && kind_ok && addr_ok;
   end

endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
   import dbg_match_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int NUM_BP  = 4,
   parameter int NUM_WP  = 4,
   parameter bit REG_OUT = 1'b1,
   localparam int SLOT_W = idx_bits((NUM_BP > NUM_WP) ? NUM_BP : NUM_WP)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic              cfg_kind,
   input  logic              cfg_clr,
   input  logic [SLOT_W-1:0] cfg_slot,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [1:0]        cfg_mode,
   input  logic              pc_valid,
   input  logic [ADDR_W-1:0] pc,
   input  logic              mem_req,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   output logic              mem_block,
   output logic              bp_req,
   output logic              wp_req
);

   initial begin
      if (ADDR_W < 2 || ADDR_W > 64)   $error("dbg_match_unit: ADDR_W out of range");
      if (NUM_BP < 1 || NUM_BP > 16)   $error("dbg_match_unit: NUM_BP out of range");
      if (NUM_WP < 1 || NUM_WP > 16)   $error("dbg_match_unit: NUM_WP out of range");
   end

   logic                       bp_wr, wp_wr;
   logic [NUM_BP-1:0]          bp_valid_w;
   logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr_w;
   logic [NUM_BP-1:0][1:0]     bp_mode_unused;
   logic [NUM_WP-1:0]          wp_valid_w;
   logic [NUM_WP-1:0][ADDR_W-1:0] wp_addr_w;
   logic [NUM_WP-1:0][1:0]     wp_mode_w;
   logic [NUM_BP-1:0]          bp_hit_vec;
   logic [NUM_WP-1:0]          wp_hit_vec;
   logic                       bp_any, wp_any;

   assign bp_wr = cfg_wr && !cfg_kind;
   assign wp_wr = cfg_wr &&  cfg_kind;

   dbg_slot_bank #(
      .NUM(NUM_BP), .ADDR_W(ADDR_W), .IDX_W(SLOT_W), .HAS_MODE(1'b0)
   ) u_bp_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bp_wr), .wr_clr(cfg_clr), .wr_idx(cfg_slot),
      .wr_addr(cfg_addr), .wr_mode(cfg_mode),
      .slot_valid(bp_valid_w), .slot_addr(bp_addr_w), .slot_mode(bp_mode_unused)
   );

   dbg_slot_bank #(
      .NUM(NUM_WP), .ADDR_W(ADDR_W), .IDX_W(SLOT_W), .HAS_MODE(1'b1)
   ) u_wp_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wp_wr), .wr_clr(cfg_clr), .wr_idx(cfg_slot),
      .wr_addr(cfg_addr), .wr_mode(cfg_mode),
      .slot_valid(wp_valid_w), .slot_addr(wp_addr_w), .slot_mode(wp_mode_w)
   );

   dbg_bp_cmp #(.NUM(NUM_BP), .ADDR_W(ADDR_W)) u_bp_cmp (
      .slot_valid(bp_valid_w), .slot_addr(bp_addr_w),
      .pc_valid(pc_valid), .pc(pc), .hit_vec(bp_hit_vec)
   );

   dbg_wp_cmp #(.NUM(NUM_WP), .ADDR_W(ADDR_W)) u_wp_cmp (
      .slot_valid(wp_valid_w), .slot_addr(wp_addr_w), .slot_mode(wp_mode_w),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .hit_vec(wp_hit_vec)
   );

   assign bp_any    = |bp_hit_vec;
   assign wp_any    = |wp_hit_vec;
   // The block path stays combinational so the access is stopped in its own cycle.
   assign mem_block = wp_any;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bp_req <= 1'b0;
            wp_req <= 1'b0;
         end else begin
            bp_req <= bp_any;
            wp_req <= wp_any;
         end
      end
   end else begin : g_comb_out
      assign bp_req = bp_any;
      assign wp_req = wp_any;
   end

endmodule

// File: rtl/dbg_match_chk.sv
module dbg_match_chk #(
   parameter int NUM_BP  = 4,
   parameter int NUM_WP  = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   pc_valid,
   input logic                   mem_req,
   input logic                   mem_we,
   input logic                   mem_block,
   input logic                   bp_req,
   input logic                   wp_req,
   input logic [NUM_BP-1:0]      bp_hit_vec,
   input logic [NUM_WP-1:0]      wp_hit_vec,
   input logic [NUM_WP-1:0]      wp_valid,
   input logic [NUM_WP-1:0][1:0] wp_mode
);

   assert_block_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_block |-> mem_req);

   assert_hit_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|wp_hit_vec) |-> mem_block);

   assert_bp_needs_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (|bp_hit_vec) |-> pc_valid);

   if (REG_OUT) begin : g_reg
      assert_reset_quiet_R1: assert property (@(posedge clk)
         !rst_n |=> (!bp_req && !wp_req));

      assert_bp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (|bp_hit_vec) |=> bp_req);

      assert_bp_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
         bp_req |-> $past(pc_valid));

      assert_wp_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
         mem_block |=> wp_req);

      assert_wp_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
         wp_req |-> $past(mem_block));
   end

   for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
      assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wp_mode[g] == 2'd0) |-> !wp_hit_vec[g]);

      assert_cleared_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !wp_valid[g] |-> !wp_hit_vec[g]);

      assert_load_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (wp_mode[g] == 2'd1 && mem_we) |-> !wp_hit_vec[g]);

      assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (wp_mode[g] == 2'd2 && !mem_we) |-> !wp_hit_vec[g]);
   end

endmodule

bind dbg_match_unit dbg_match_chk #(
   .NUM_BP(NUM_BP), .NUM_WP(NUM_WP), .REG_OUT(REG_OUT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .mem_req(mem_req),
   .mem_we(mem_we), .mem_block(mem_block), .bp_req(bp_req), .wp_req(wp_req),
   .bp_hit_vec(bp_hit_vec), .wp_hit_vec(wp_hit_vec),
   .wp_valid(wp_valid_w), .wp_mode(wp_mode_w)
);

// File: tb/test_dbg_match_unit.sv
`timescale 1ns/1ps
module test_dbg_match_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 0, cfg_kind = 0, cfg_clr = 0;
   logic [1:0]  cfg_slot = 0, cfg_mode = 0;
   logic [31:0] cfg_addr = 0;
   logic        pc_valid = 0;
   logic [31:0] pc = 0;
   logic        mem_req = 0, mem_we = 0;
   logic [31:0] mem_addr = 0;
   logic        mem_block, bp_req, wp_req;

   always #10 clk = ~clk;   // 50 MHz

   dbg_match_unit i_dbg_match_unit (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_kind(cfg_kind),
      .cfg_clr(cfg_clr), .cfg_slot(cfg_slot), .cfg_addr(cfg_addr),
      .cfg_mode(cfg_mode), .pc_valid(pc_valid), .pc(pc), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_block(mem_block),
      .bp_req(bp_req), .wp_req(wp_req)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   bit    checking = 0;
   bit    done = 0;
   string cur_req = "R1";

   // Reference model state
   bit          m_bp_v[4];
   logic [31:0] m_bp_a[4];
   bit          m_wp_v[4];
   logic [31:0] m_wp_a[4];
   int          m_wp_m[4];
   bit          exp_bp = 0, exp_wp = 0;

   function automatic bit model_bp();
      bit h = 0;
      if (!pc_valid) return 0;
      foreach (m_bp_v[i]) if (m_bp_v[i] && m_bp_a[i] == pc) h = 1;
      return h;
   endfunction

   function automatic bit model_wp();
      bit h = 0;
      if (!mem_req) return 0;
      foreach (m_wp_v[i]) begin
         bit kind_ok;
         kind_ok = (m_wp_m[i] == 3) || (m_wp_m[i] == 1 && !mem_we) || (m_wp_m[i] == 2 && mem_we);
         if (m_wp_v[i] && kind_ok && m_wp_a[i] == mem_addr) h = 1;
      end
      return h;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_bp_v[i]) begin m_bp_v[i] = 0; m_wp_v[i] = 0; m_wp_m[i] = 0; end
         exp_bp = 0;
         exp_wp = 0;
      end else begin
         exp_bp = model_bp();
         exp_wp = model_wp();
         if (cfg_wr) begin
            if (!cfg_kind) begin
               m_bp_v[cfg_slot] = !cfg_clr;
               m_bp_a[cfg_slot] = cfg_addr;
            end else begin
               m_wp_v[cfg_slot] = !cfg_clr;
               m_wp_a[cfg_slot] = cfg_addr;
               m_wp_m[cfg_slot] = cfg_clr ? 0 : int'(cfg_mode);
            end
         end
      end
   end

   task automatic chk(input string what, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (checking && !done) begin
         chk("mem_block", mem_block, rst_n ? model_wp() : 1'b0);
         chk("bp_req", bp_req, exp_bp);
         chk("wp_req", wp_req, exp_wp);
      end
   end

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic cfg(input bit kind, input bit clr, input int slot, input logic [31:0] a, input int m);
      cfg_wr = 1; cfg_kind = kind; cfg_clr = clr; cfg_slot = 2'(slot);
      cfg_addr = a; cfg_mode = 2'(m);
      tick();
      cfg_wr = 0;
   endtask

   task automatic fetch(input logic [31:0] a, input bit v = 1);
      pc_valid = v; pc = a;
      tick();
      pc_valid = 0;
   endtask

   task automatic access(input bit we, input logic [31:0] a);
      mem_req = 1; mem_we = we; mem_addr = a;
      tick();
      mem_req = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      repeat (2) @(posedge clk);
      #2 checking = 1;
      fetch(32'h0);
      access(1, 32'h0);
      tick();
      rst_n = 1;
      tick();
      access(0, 32'h0);
      fetch(32'h0);
      tick();

      cur_req = "R2";
      cfg(0, 0, 1, 32'h1000, 0);
      fetch(32'h1000);
      fetch(32'h1004);
      fetch(32'h1000, 0);
      tick();

      cur_req = "R3";
      cfg(1, 0, 0, 32'h2000, 0);
      access(0, 32'h2000);
      access(1, 32'h2000);
      tick();

      cur_req = "R4";
      cfg(1, 0, 1, 32'h2100, 1);
      access(0, 32'h2100);
      access(1, 32'h2100);
      tick();

      cur_req = "R5";
      cfg(1, 0, 2, 32'h2200, 2);
      access(1, 32'h2200);
      access(0, 32'h2200);
      tick();

      cur_req = "R6";
      cfg(1, 0, 3, 32'h2300, 3);
      access(0, 32'h2300);
      access(1, 32'h2300);
      tick();

      cur_req = "R7";
      access(0, 32'h2101);
      access(0, 32'h20FF);
      access(1, 32'h2301);
      access(1, 32'h22FF);
      tick();

      cur_req = "R8";
      access(1, 32'h2300);
      access(1, 32'h2300);
      tick();

      cur_req = "R9";
      cfg(1, 1, 3, 32'h0, 0);
      access(1, 32'h2300);
      cfg(1, 1, 3, 32'h0, 0);
      access(0, 32'h2100);
      cfg(0, 1, 1, 32'h0, 0);
      fetch(32'h1000);
      tick();

      cur_req = "R10";
      cfg_wr = 1; cfg_kind = 1; cfg_clr = 0; cfg_slot = 2'd3;
      cfg_addr = 32'h2400; cfg_mode = 2'd3;
      mem_req = 1; mem_we = 1; mem_addr = 32'h2400;
      tick();
      cfg_wr = 0;
      tick();
      mem_req = 0;
      tick();

      cur_req = "R11";
      cfg(0, 0, 0, 32'h3000, 0);
      cfg(0, 0, 2, 32'h3100, 0);
      fetch(32'h3000);
      fetch(32'h3100);
      pc_valid = 1; pc = 32'h3100; mem_req = 1; mem_we = 0; mem_addr = 32'h2100;
      tick();
      pc_valid = 0; mem_req = 0;
      tick();

      for (int k = 0; k < 400; k++) begin
         logic [31:0] pool[6] = '{32'h1000, 32'h2100, 32'h2200, 32'h2400, 32'h3000, 32'h3100};
         cfg_wr   = ($urandom_range(0, 7) == 0);
         cfg_kind = 1'($urandom);
         cfg_clr  = ($urandom_range(0, 3) == 0);
         cfg_slot = 2'($urandom);
         cfg_addr = pool[$urandom_range(0, 5)];
         cfg_mode = 2'($urandom);
         pc_valid = 1'($urandom);
         pc       = pool[$urandom_range(0, 5)];
         mem_req  = 1'($urandom);
         mem_we   = 1'($urandom);
         mem_addr = pool[$urandom_range(0, 5)];
         tick();
      end
      cfg_wr = 0; pc_valid = 0; mem_req = 0;
      tick();
      tick();

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule